// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block sits between a single-master request port and an asynchronous 256K x 16 dynamic RAM that uses a multiplexed address bus. Each host request carries an 18-bit word address, a write flag, two byte enables and write data. The block turns it into a timed sequence of row strobe, per-byte column strobes, write enable and output enable. The upper nine address bits go out as the row and the lower nine as the column. Every timing limit is a parameter counted in clock cycles.

After a row has been opened, the block keeps it open. A following request to the same row is served by cycling only the column strobes, so the row strobe stays low. The page is closed in three cases: the next request targets another row, the host drops its request, or an external refresh scheduler raises `stop_req`. Closing waits until the minimum row-active time has passed, and the following precharge lasts at least the row precharge time. Writes are early writes: write enable and data are valid one cycle before the column strobe falls. The data bus is driven only while a write is in progress.

The state machine has eight states. IDLE has the row closed and accepts a request. RSET puts the row on the bus with the row strobe still high. RCD holds the row strobe low for the row-to-column delay. CSET places the column, write enable, output enable and data. CASL holds the selected column strobes low. CPRE is the column precharge. PAGE keeps the row open and waits for a same-row request. CLOSE is the row precharge.

The transitions are:
- IDLE→RSET when a request is accepted.
- RSET→RCD after one cycle.
- RCD→CSET when the delay expires.
- CSET→CASL after one cycle.
- CASL→CPRE when the strobe width expires.
- CPRE→PAGE when the precharge expires.
- PAGE→CSET when a same-row request is accepted.
- PAGE→CLOSE once the row-active time has been met and no same-row request can be accepted.
- CLOSE→IDLE when the row precharge expires.

Top module: `fpm_ctl`

## Requirements
- R1: While reset is held, `ras_n`, `ucas_n`, `lcas_n`, `we_n` and `oe_n` are high, and `dq_oe` and `rsp_valid` are low. After reset with `stop_req` low, `req_ready` is high.
- R2: On the falling edge of `ras_n`, `dram_addr` carries `req_addr[17:9]`. On the falling edge of a column strobe, it carries `req_addr[8:0]`.
- R3: `req_be[0]` selects `lcas_n`, which covers data bits 7:0. `req_be[1]` selects `ucas_n`, which covers bits 15:8. Only the selected strobes go low, and they fall together.
- R4: Successive requests to the open row are served with `ras_n` held low, so there is exactly one row-strobe falling edge for the whole run.
- R5: A request to a different row closes the page. `ras_n` stays high for at least T_RP cycles before the new row is opened.
- R6: When the host drops `req_valid`, or while `stop_req` is high, the open page is closed after T_RAS is met. While `stop_req` is high, `req_ready` is low.
- R7: A read holds `we_n` high and `oe_n` low while a column strobe is low. After the strobe window, `rsp_valid` pulses for one cycle with the read data. Bytes that were not enabled read as zero.
- R8: For a write, `we_n` is low and `dq_o` is driven one cycle before the column strobe falls. At that falling edge, `dq_o` holds the request's data.
- R9: `dq_oe` is high only while `we_n` is low and `ras_n` is low.
- R10: A column strobe is low only while `ras_n` is low. Row-to-column delay is at least T_RCD, column strobe low time at least T_CAS, column precharge at least T_CP, and row strobe low time at least T_RAS.
- R11: Only one request is outstanding. `req_ready` is high only while both column strobes and `we_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address; [17:9] row, [8:0] column |
| req_be | input | 2 | Byte enables; [0] low byte, [1] high byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read data pulse |
| rsp_rdata | output | 16 | Read data; disabled bytes zero |
| stop_req | input | 1 | Close the page and hold off new requests |
| dram_addr | output | 9 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dq_o | output | 16 | Write data to memory |
| dq_oe | output | 1 | Data bus drive enable |
| dq_i | input | 16 | Read data from memory |

## Verification
Back-to-back writes and reads within one row show that the row strobe falls only once. Alternating rows force a precharge and a second activation, which separates page hits from misses. Lower-only and upper-only writes over a known word, followed by full and partial reads, show each strobe reaching only its own byte and the masking of read data. A request held pending while `stop_req` is high, and a host that goes quiet, both show the page closing for reasons other than a row change.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RSET, ST_RCD, ST_CSET,
        ST_CASL, ST_CPRE, ST_PAGE, ST_CLOSE
    } fpm_state_t;
endpackage

// File: rtl/fpm_timer.sv
`timescale 1ns/1ps
module fpm_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/fpm_row_tag.sv
`timescale 1ns/1ps
module fpm_row_tag #(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [ROW_W-1:0] row_in,
    output logic [ROW_W-1:0] open_row,
    output logic             hit
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_row <= '0;
        else if (capture)
            open_row <= row_in;
    end

    assign hit = (row_in == open_row);
endmodule

// File: rtl/fpm_ctl.sv
`timescale 1ns/1ps
module fpm_ctl
    import fpm_pkg::*;
#(
    parameter int HALF_W = 9,
    parameter int T_RCD  = 2,
    parameter int T_CAS  = 2,
    parameter int T_CP   = 1,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [2*HALF_W-1:0] req_addr,
    input  logic [LANES-1:0]    req_be,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    input  logic                stop_req,
    output logic [HALF_W-1:0]   dram_addr,
    output logic                ras_n,
    output logic                ucas_n,
    output logic                lcas_n,
    output logic                we_n,
    output logic                oe_n,
    output logic [DATA_W-1:0]   dq_o,
    output logic                dq_oe,
    input  logic [DATA_W-1:0]   dq_i
);
    localparam int ADDR_W = 2 * HALF_W;
    localparam int TM_A   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int TM_B   = (T_CP > T_RP) ? T_CP : T_RP;
    localparam int TM_C   = (TM_A > TM_B) ? TM_A : TM_B;
    localparam int T_MAX  = (TM_C > T_RAS) ? TM_C : T_RAS;
    localparam int CNT_W  = $clog2(T_MAX + 1);

    fpm_state_t          st_q, st_d;
    logic [HALF_W-1:0]   open_row, a_col;
    logic                a_wr;
    logic [LANES-1:0]    a_be, cas_v;
    logic [DATA_W-1:0]   a_wd, lane_mask, rdata_q;
    logic                rsp_q, row_hit, accept;
    logic                step_load, step_done, ras_load, ras_done;
    logic [CNT_W-1:0]    step_len;

    // per-lane read mask built from the captured byte enables
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{a_be[g]}};
    end

    fpm_row_tag #(.ROW_W(HALF_W)) u_tag (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (accept && (st_q == ST_IDLE)),
        .row_in   (req_addr[ADDR_W-1:HALF_W]),
        .open_row (open_row),
        .hit      (row_hit)
    );

    fpm_timer #(.CNT_W(CNT_W)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (step_load),
        .len   (step_len),
        .done  (step_done)
    );

    fpm_timer #(.CNT_W(CNT_W)) u_ras (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ras_load),
        .len   (CNT_W'(T_RAS)),
        .done  (ras_done)
    );

    always_comb begin
        st_d      = st_q;
        step_load = 1'b0;
        step_len  = '0;
        ras_load  = 1'b0;
        req_ready = !stop_req && ((st_q == ST_IDLE) || ((st_q == ST_PAGE) && row_hit));
        accept    = req_valid && req_ready;
        unique case (st_q)
            ST_IDLE:  if (accept) st_d = ST_RSET;
            ST_RSET: begin
                st_d      = ST_RCD;
                step_load = 1'b1;
                step_len  = CNT_W'(T_RCD);
                ras_load  = 1'b1;
            end
            ST_RCD:   if (step_done) st_d = ST_CSET;
            ST_CSET: begin
                st_d      = ST_CASL;
                step_load = 1'b1;
                step_len  = CNT_W'(T_CAS);
            end
            ST_CASL: if (step_done) begin
                st_d      = ST_CPRE;
                step_load = 1'b1;
                step_len  = CNT_W'(T_CP);
            end
            ST_CPRE:  if (step_done) st_d = ST_PAGE;
            ST_PAGE: begin
                if (accept)
                    st_d = ST_CSET;
                else if (ras_done) begin
                    st_d      = ST_CLOSE;
                    step_load = 1'b1;
                    step_len  = CNT_W'(T_RP);
                end
            end
            ST_CLOSE: if (step_done) st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_col <= '0;
            a_wr  <= 1'b0;
            a_be  <= '0;
            a_wd  <= '0;
        end else if (accept) begin
            a_col <= req_addr[HALF_W-1:0];
            a_wr  <= req_write;
            a_be  <= req_be;
            a_wd  <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            rsp_q <= (st_q == ST_CASL) && step_done && !a_wr;
            if ((st_q == ST_CASL) && step_done && !a_wr)
                rdata_q <= dq_i & lane_mask;
        end
    end

    always_comb begin
        ras_n     = 1'b1;
        cas_v     = '1;
        we_n      = 1'b1;
        oe_n      = 1'b1;
        dq_oe     = 1'b0;
        dram_addr = a_col;
        unique case (st_q)
            ST_IDLE, ST_CLOSE: dram_addr = open_row;
            ST_RSET:           dram_addr = open_row;
            ST_RCD: begin
                dram_addr = open_row;
                ras_n     = 1'b0;
            end
            ST_CSET, ST_CASL: begin
                ras_n = 1'b0;
                we_n  = !a_wr;
                oe_n  = a_wr;
                dq_oe = a_wr;
                if (st_q == ST_CASL) cas_v = ~a_be;
            end
            ST_CPRE, ST_PAGE:  ras_n = 1'b0;
        endcase
    end

    assign lcas_n    = cas_v[0];
    assign ucas_n    = cas_v[LANES-1];
    assign dq_o      = a_wd;
    assign rsp_valid = rsp_q;
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/fpm_ctl_chk.sv
`timescale 1ns/1ps
module fpm_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic stop_req,
    input logic rsp_valid,
    input logic ras_n,
    input logic ucas_n,
    input logic lcas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe
);
    // R10
    cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ucas_n || !lcas_n) |-> !ras_n);

    // R9
    drive_wr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!we_n && !ras_n));

    // R8
    early_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && ($fell(lcas_n) || $fell(ucas_n))) |-> $past(!we_n && dq_oe));

    // R7
    rd_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ucas_n || !lcas_n) && we_n) |-> !oe_n);

    // R7
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    stop_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> !req_ready);

    // R11
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ucas_n && lcas_n && we_n));
endmodule

bind fpm_ctl fpm_ctl_chk u_chk (.*);

// File: tb/sim_fpm_ctl.sv
`timescale 1ns/1ps
module sim_fpm_ctl;
    localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 3, T_RAS = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, stop_req = 1'b0;
    logic [17:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0, dq_i = '0;
    logic        req_ready, rsp_valid, ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe;
    logic [15:0] rsp_rdata, dq_o;
    logic [8:0]  dram_addr;

    always #10 clk = ~clk;

    fpm_ctl u0 (.*);

    int n_chk = 0, n_err = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] mk(input int row, input int col);
        return {row[8:0], col[8:0]};
    endfunction

    // behavioural memory and scoreboard
    logic [15:0] mem [int];
    logic [15:0] gold [int];
    logic [15:0] rdq [$];
    logic [17:0] cur_addr;
    logic [1:0]  cur_be;
    logic [15:0] cur_wd;
    logic [8:0]  row_m, col_m;
    bit ras_p = 1, cas_p = 1, we_p = 1, oe_p_drv = 0;
    int ras_hi = 100, ras_lo = 0, cas_hi = 100, cas_lo = 0, rcd = 0, ras_falls = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            logic cas_now;
            logic [15:0] v, m;
            cas_now = ucas_n && lcas_n;
            // host acceptance
            if (req_valid && req_ready) begin
                cur_addr = req_addr; cur_be = req_be; cur_wd = req_wdata;
                v = gold.exists(int'(req_addr)) ? gold[int'(req_addr)] : 16'h0;
                m = {{8{req_be[1]}}, {8{req_be[0]}}};
                if (req_write) gold[int'(req_addr)] = (v & ~m) | (req_wdata & m);
                else rdq.push_back(v & m);
            end
            // invariants
            if (stop_req) chk(!req_ready, "R6 ready while stop", req_ready, 0);
            if (dq_oe) chk(!we_n && !ras_n, "R9 drive outside write", {we_n, ras_n}, 0);
            if (req_ready) chk(cas_now && we_n, "R11 ready while busy", {ucas_n, lcas_n, we_n}, 3'b111);
            // row strobe edges
            if (ras_p && !ras_n) begin
                ras_falls++;
                chk(ras_hi >= T_RP, "R5 row precharge", ras_hi, T_RP);
                chk(dram_addr == cur_addr[17:9], "R2 row address", dram_addr, cur_addr[17:9]);
                row_m = dram_addr; rcd = 0; ras_lo = 0;
            end
            if (!ras_p && ras_n) chk(ras_lo >= T_RAS, "R10 row active time", ras_lo, T_RAS);
            // column strobe edges
            if (cas_p && !cas_now) begin
                chk(!ras_n, "R10 column inside row", ras_n, 0);
                chk(rcd >= T_RCD, "R10 row to column", rcd, T_RCD);
                chk(cas_hi >= T_CP, "R10 column precharge", cas_hi, T_CP);
                chk({ucas_n, lcas_n} == ~cur_be, "R3 strobe select", {ucas_n, lcas_n}, ~cur_be);
                chk(dram_addr == cur_addr[8:0], "R2 column address", dram_addr, cur_addr[8:0]);
                col_m = dram_addr; cas_lo = 0;
                if (!we_n) begin
                    chk(!we_p && oe_p_drv, "R8 early write setup", {we_p, oe_p_drv}, 2'b01);
                    chk(dq_o == cur_wd, "R8 write data", dq_o, cur_wd);
                    v = mem.exists(int'({row_m, col_m})) ? mem[int'({row_m, col_m})] : 16'h0;
                    if (!lcas_n) v[7:0] = dq_o[7:0];
                    if (!ucas_n) v[15:8] = dq_o[15:8];
                    mem[int'({row_m, col_m})] = v;
                end else begin
                    chk(!oe_n, "R7 output enable on read", oe_n, 0);
                end
            end
            if (!cas_p && cas_now) begin
                chk(cas_lo >= T_CAS, "R10 column strobe width", cas_lo, T_CAS);
                cas_hi = 0;
            end
            // read response
            if (rsp_valid) begin
                if (rdq.size() == 0) chk(0, "R7 unexpected response", rsp_rdata, 0);
                else begin
                    v = rdq.pop_front();
                    chk(rsp_rdata == v, "R7 read data", rsp_rdata, v);
                end
            end
            // memory drives read data
            v = mem.exists(int'({row_m, col_m})) ? mem[int'({row_m, col_m})] : 16'h0;
            dq_i = 16'hA5A5;
            if (!ras_n && we_n && !lcas_n) dq_i[7:0] = v[7:0];
            if (!ras_n && we_n && !ucas_n) dq_i[15:8] = v[15:8];
            // counters
            if (ras_n) ras_hi++; else begin ras_hi = 0; ras_lo++; rcd++; end
            if (cas_now) cas_hi++; else cas_lo++;
            ras_p = ras_n; cas_p = cas_now; we_p = we_n; oe_p_drv = dq_oe;
        end
    end

    task automatic issue(input bit wr, input logic [17:0] a, input logic [1:0] be, input logic [15:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        int k = 0;
        while ((rdq.size() != 0) && (k < 200)) begin @(negedge clk); k++; end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({ras_n, ucas_n, lcas_n, we_n, oe_n} == 5'h1F, "R1 strobes idle", {ras_n, ucas_n, lcas_n, we_n, oe_n}, 5'h1F);
        chk(!dq_oe && !rsp_valid, "R1 bus and response idle", {dq_oe, rsp_valid}, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R1 ready after reset", req_ready, 1);

        // R7 R2 write then read, same row (R4)
        f0 = ras_falls;
        issue(1, mk(5, 3), 2'b11, 16'h1234);
        issue(0, mk(5, 3), 2'b11, 16'h0);
        drain();
        chk(ras_falls - f0 == 1, "R4 single activation", ras_falls - f0, 1);

        // R4 page burst
        f0 = ras_falls;
        for (int i = 0; i < 4; i++) issue(1, mk(7, i), 2'b11, 16'h1100 + 16'(i * 17));
        for (int i = 0; i < 4; i++) issue(0, mk(7, i), 2'b11, 16'h0);
        drain();
        chk(ras_falls - f0 == 1, "R4 burst on one row", ras_falls - f0, 1);

        // R3 byte lanes
        issue(1, mk(7, 10), 2'b11, 16'hAAAA);
        issue(1, mk(7, 10), 2'b01, 16'h5533);
        issue(1, mk(7, 10), 2'b10, 16'h4466);
        issue(0, mk(7, 10), 2'b11, 16'h0);
        issue(0, mk(7, 10), 2'b01, 16'h0);
        issue(0, mk(7, 10), 2'b10, 16'h0);
        drain();

        // R5 row miss
        f0 = ras_falls;
        issue(1, mk(9, 1), 2'b11, 16'hBEEF);
        issue(0, mk(5, 3), 2'b11, 16'h0);
        issue(0, mk(9, 1), 2'b11, 16'h0);
        drain();
        chk(ras_falls - f0 == 3, "R5 reopen per row change", ras_falls - f0, 3);

        // R6 host idle closes the page
        repeat (20) @(negedge clk);
        chk(ras_n, "R6 close when idle", ras_n, 1);

        // R6 stop request closes page and blocks a pending same-row read
        issue(1, mk(3, 0), 2'b11, 16'hC0DE);
        stop_req = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = mk(3, 0); req_be = 2'b11;
        repeat (20) @(negedge clk);
        chk(ras_n, "R6 close on stop", ras_n, 1);
        chk(rdq.size() == 0, "R6 no accept on stop", rdq.size(), 0);
        @(posedge clk); #1 stop_req = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #1 req_valid = 1'b0;
        drain();
        chk(rdq.size() == 0, "R7 all reads answered", rdq.size(), 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule